// File: doc/BRIEF.md
# LWE Single-Bit Decryptor

This block recovers one plaintext bit from a learning-with-errors ciphertext. The ciphertext consists of a vector `u` and a scalar `v`. The secret vector `S` and the modulus `q` are also inputs. The block computes the raw value D = (v − S·u) mod q. It then decides the bit with one unsigned compare, using thresholds taken from q by right shifts. A state machine runs the work in stages:

- one multiply per element, using a single shift-add multiplier;
- a bit-serial reduction of each product modulo q;
- a modular accumulate;
- a subtract from v;
- the final compare.

The vector arrives serially as a stream. Each beat carries one element of `u` together with the matching element of `S`. A beat is transferred on a rising clock edge where `elem_valid` and `elem_ready` are both high. The block only raises `elem_ready` while it is waiting for its next element, so the source can stall as long as it likes. Each stalled cycle adds exactly one cycle to the run and has no effect on the result. The data of a beat must be held while `elem_valid` is high and `elem_ready` is low.

Holding `rst` high prepares a run. Work starts on the first clock edge after release. `mod_q`, `ct_v` and `vec_len` must stay stable from release until `done` rises. They must also satisfy 1 ≤ q and v < q. When `done` rises, the result is final and it stays frozen until the next reset.

Top module: `lwe_bit_decrypt`

## Requirements
- R1: After `done` rises, `d_val` equals (v − Σ s_i·u_i) mod q over the `vec_len` elements accepted, for any `vec_len` from 0 to 63, and `d_val` < q.
- R2: `msg_bit` is 1 exactly when ((d_val − (q>>2)) mod 2^16) < (q>>1), which is the same as (q>>2) ≤ d_val < (q>>2)+(q>>1). Otherwise `msg_bit` is 0.
- R3: While `rst` is high, `done`, `elem_ready`, `msg_bit` and `d_val` are all 0, including after a completed run.
- R4: An element is taken on each edge where `elem_valid` and `elem_ready` are both high. Exactly `vec_len` elements are taken. `elem_ready` is 0 while `done` is high.
- R5: With elements always offered, `done` rises 50·vec_len + 3 clock edges after reset release. Each cycle in which `elem_ready` is high and `elem_valid` is low delays `done` by exactly one edge and leaves the result unchanged.
- R6: Once `done` is high, `done`, `d_val` and `msg_bit` hold their values, whatever the inputs do, until reset.
- R7: Operands use the full 16-bit unsigned range: elements up to 65535 and q up to 65535, with 32-bit products reduced exactly.
- R8: With `vec_len` = 0, no element is requested and `d_val` equals v.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; held to prepare a run |
| mod_q | input | 16 | Modulus q, at least 1 |
| ct_v | input | 16 | Ciphertext scalar v, below q |
| vec_len | input | 6 | Number of vector elements, 0 to 63 |
| elem_valid | input | 1 | Source offers an element pair |
| elem_ready | output | 1 | Block accepts an element pair this cycle |
| elem_u | input | 16 | Ciphertext vector element u_i |
| elem_s | input | 16 | Secret vector element s_i |
| msg_bit | output | 1 | Decrypted bit, valid while `done` |
| d_val | output | 16 | Raw value D, valid while `done` |
| done | output | 1 | Result final and frozen |

## Verification
Every element costs a fixed 50 edges: one to accept, 16 to multiply, 32 to reduce and one to accumulate. The last element is followed by three more edges: an empty load, the subtract and the compare. `done`, `d_val` and `msg_bit` therefore all appear together 50·vec_len + 3 edges after release, plus one edge for each stalled load cycle. The bench counts edges from release up to the falling edge at which it first sees `done`, and compares that count exactly. It then reads D and the bit at that same falling edge. The frozen-result and no-request checks are made several cycles later, after the inputs have been disturbed.

// File: rtl/lwe_dec_pkg.sv
package lwe_dec_pkg;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_MUL,
    ST_MOD,
    ST_ACC,
    ST_SUB,
    ST_CMP,
    ST_DONE
  } dec_state_e;

endpackage

// File: rtl/lwe_shift_mult.sv
module lwe_shift_mult #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] mcand;
  logic [W-1:0]  mplier;

  // one multiplier bit per step, LSB first
  always_ff @(posedge clk) begin
    if (rst) begin
      mcand  <= '0;
      mplier <= '0;
      prod   <= '0;
    end else if (load) begin
      mcand  <= {{W{1'b0}}, a};
      mplier <= b;
      prod   <= '0;
    end else if (step) begin
      if (mplier[0]) prod <= prod + mcand;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
    end
  end

endmodule

// File: rtl/lwe_serial_mod.sv
module lwe_serial_mod #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         din,
  input  logic [W-1:0] modulus,
  output logic [W-1:0] rem
);
  logic [W:0] trial;

  // restoring remainder: shift one dividend bit in, subtract once if possible
  assign trial = {rem, din};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rem <= '0;
    end else if (step) begin
      if (trial >= {1'b0, modulus}) rem <= W'(trial - {1'b0, modulus});
      else                          rem <= trial[W-1:0];
    end
  end

  // R1: partial remainder always stays reduced
  assert_rem_below_mod_R1: assert property (@(posedge clk) disable iff (rst)
    step |=> (rem < modulus));

endmodule

// File: rtl/lwe_bit_decrypt.sv
module lwe_bit_decrypt
  import lwe_dec_pkg::*;
#(
  parameter int W     = 16,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     mod_q,
  input  logic [W-1:0]     ct_v,
  input  logic [LEN_W-1:0] vec_len,
  input  logic             elem_valid,
  output logic             elem_ready,
  input  logic [W-1:0]     elem_u,
  input  logic [W-1:0]     elem_s,
  output logic             msg_bit,
  output logic [W-1:0]     d_val,
  output logic             done
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(PW);
  localparam logic [CW-1:0] MUL_LAST = CW'(W - 1);
  localparam logic [CW-1:0] MOD_LAST = CW'(PW - 1);

  dec_state_e       state;
  logic [CW-1:0]    cnt;
  logic [LEN_W-1:0] idx;
  logic [W-1:0]     acc;
  logic [PW-1:0]    prod;
  logic [W-1:0]     rem;
  logic [CW-1:0]    bit_sel;
  logic [W:0]       acc_sum;
  logic             take;

  assign elem_ready = !rst && (state == ST_LOAD) && (idx != vec_len);
  assign take       = elem_valid && elem_ready;
  assign done       = !rst && (state == ST_DONE);
  assign bit_sel    = MOD_LAST - cnt;
  assign acc_sum    = {1'b0, acc} + {1'b0, rem};

  lwe_shift_mult #(.W(W)) u_mult (
    .clk  (clk),
    .rst  (rst),
    .load (take),
    .step (state == ST_MUL),
    .a    (elem_u),
    .b    (elem_s),
    .prod (prod)
  );

  lwe_serial_mod #(.W(W)) u_mod (
    .clk     (clk),
    .rst     (rst),
    .clr     (take),
    .step    (state == ST_MOD),
    .din     (prod[bit_sel]),
    .modulus (mod_q),
    .rem     (rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_LOAD;
      cnt     <= '0;
      idx     <= '0;
      acc     <= '0;
      d_val   <= '0;
      msg_bit <= 1'b0;
    end else begin
      unique case (state)
        ST_LOAD: begin
          if (idx == vec_len) begin
            state <= ST_SUB;
          end else if (take) begin
            cnt   <= '0;
            state <= ST_MUL;
          end
        end
        ST_MUL: begin
          if (cnt == MUL_LAST) begin
            cnt   <= '0;
            state <= ST_MOD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_MOD: begin
          if (cnt == MOD_LAST) begin
            cnt   <= '0;
            state <= ST_ACC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACC: begin
          if (acc_sum >= {1'b0, mod_q}) acc <= W'(acc_sum - {1'b0, mod_q});
          else                          acc <= acc_sum[W-1:0];
          idx   <= idx + 1'b1;
          state <= ST_LOAD;
        end
        ST_SUB: begin
          // result is below q, so W-bit wraparound gives the exact value
          if (ct_v < acc) d_val <= ct_v + mod_q - acc;
          else            d_val <= ct_v - acc;
          state <= ST_CMP;
        end
        ST_CMP: begin
          msg_bit <= (d_val - (mod_q >> 2)) < (mod_q >> 1);
          state   <= ST_DONE;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  // R1: running sum stays reduced between elements
  assert_acc_reduced_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD) |-> (acc < mod_q));

  // R1: final value lies inside [0, q)
  assert_d_below_q_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (d_val < mod_q));

  // R2: decision matches the window form of the threshold
  assert_bit_window_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (msg_bit == ((d_val >= (mod_q >> 2)) &&
      ({1'b0, d_val} < ({1'b0, mod_q >> 2} + {1'b0, mod_q >> 1})))));

  // R4: no element requested once finished
  assert_no_req_when_done_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !elem_ready);

  // R6: result frozen after completion
  assert_hold_after_done_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(d_val) && $stable(msg_bit)));

endmodule

// File: tb/lwe_bit_decrypt_tb.sv
module lwe_bit_decrypt_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0]      q;
    logic [15:0]      v;
    logic [5:0]       n;
    logic [0:3][15:0] u;
    logic [0:3][15:0] s;
    logic [15:0]      d;
    logic             b;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{q:16'd23,    v:16'd10,    n:6'd0, u:'{16'd0,16'd0,16'd0,16'd0},
      s:'{16'd0,16'd0,16'd0,16'd0}, d:16'd10, b:1'b1},
    '{q:16'd23,    v:16'd20,    n:6'd2, u:'{16'd3,16'd4,16'd0,16'd0},
      s:'{16'd2,16'd5,16'd0,16'd0}, d:16'd17, b:1'b0},
    '{q:16'd23,    v:16'd4,     n:6'd3, u:'{16'd1,16'd1,16'd1,16'd0},
      s:'{16'd7,16'd7,16'd7,16'd0}, d:16'd6, b:1'b1},
    '{q:16'd65521, v:16'd0,     n:6'd4, u:'{16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF},
      s:'{16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF}, d:16'd64737, b:1'b0},
    '{q:16'd65521, v:16'd49380, n:6'd1, u:'{16'd1000,16'd0,16'd0,16'd0},
      s:'{16'd33,16'd0,16'd0,16'd0}, d:16'd16380, b:1'b1},
    '{q:16'd23,    v:16'd4,     n:6'd1, u:'{16'd0,16'd0,16'd0,16'd0},
      s:'{16'd9,16'd0,16'd0,16'd0}, d:16'd4, b:1'b0},
    '{q:16'd23,    v:16'd16,    n:6'd0, u:'{16'd0,16'd0,16'd0,16'd0},
      s:'{16'd0,16'd0,16'd0,16'd0}, d:16'd16, b:1'b0},
    '{q:16'd23,    v:16'd15,    n:6'd0, u:'{16'd0,16'd0,16'd0,16'd0},
      s:'{16'd0,16'd0,16'd0,16'd0}, d:16'd15, b:1'b1},
    '{q:16'd1000,  v:16'd0,     n:6'd2, u:'{16'd999,16'd500,16'd0,16'd0},
      s:'{16'd999,16'd2,16'd0,16'd0}, d:16'd999, b:1'b0},
    '{q:16'd4,     v:16'd2,     n:6'd1, u:'{16'd3,16'd0,16'd0,16'd0},
      s:'{16'd3,16'd0,16'd0,16'd0}, d:16'd1, b:1'b1},
    '{q:16'd65535, v:16'd65534, n:6'd1, u:'{16'hFFFF,16'd0,16'd0,16'd0},
      s:'{16'hFFFF,16'd0,16'd0,16'd0}, d:16'd65534, b:1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mod_q = 16'd23;
  logic [15:0] ct_v = 16'd0;
  logic [5:0]  vec_len = 6'd0;
  logic        elem_valid = 1'b0;
  logic        elem_ready;
  logic [15:0] elem_u = 16'd0;
  logic [15:0] elem_s = 16'd0;
  logic        msg_bit;
  logic [15:0] d_val;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lwe_bit_decrypt u_dut (
    .clk        (clk),
    .rst        (rst),
    .mod_q      (mod_q),
    .ct_v       (ct_v),
    .vec_len    (vec_len),
    .elem_valid (elem_valid),
    .elem_ready (elem_ready),
    .elem_u     (elem_u),
    .elem_s     (elem_s),
    .msg_bit    (msg_bit),
    .d_val      (d_val),
    .done       (done)
  );

  task automatic check(input string tag, input string what,
                       input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, actual, expected);
    end
  endtask

  // Resets, applies one vector with an optional stall before each element,
  // and returns the edge count from release to completion.
  task automatic run_vec(input vec_t t, input int gap, output int lat);
    @(negedge clk);
    rst        = 1'b1;
    elem_valid = 1'b0;
    mod_q      = t.q;
    ct_v       = t.v;
    vec_len    = t.n;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    lat = 0;
    fork
      begin
        for (int k = 0; k < int'(t.n); k++) begin
          elem_valid = 1'b0;
          while (!elem_ready) @(negedge clk);
          repeat (gap) @(negedge clk);
          elem_u     = t.u[k];
          elem_s     = t.s[k];
          elem_valid = 1'b1;
          @(negedge clk);
        end
        elem_valid = 1'b0;
      end
      begin
        while (!done && lat < 5000) begin
          @(negedge clk);
          lat++;
        end
      end
    join
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    vec_t t;

    // R3: reset state while stimulus is being offered
    elem_valid = 1'b1;
    vec_len    = 6'd3;
    repeat (3) @(negedge clk);
    check("R3", "done in reset", int'(done), 0);
    check("R3", "elem_ready in reset", int'(elem_ready), 0);
    check("R3", "d_val in reset", int'(d_val), 0);
    check("R3", "msg_bit in reset", int'(msg_bit), 0);

    // table of vectors, no stalls
    for (int i = 0; i < NV; i++) begin
      string dtag;
      t = TBL[i];
      run_vec(t, 0, lat);
      if (t.n == 6'd0)          dtag = "R8";
      else if (t.q >= 16'd65521) dtag = "R7";
      else                      dtag = "R1";
      check("R5", $sformatf("latency vec %0d", i), lat, 50 * int'(t.n) + 3);
      check(dtag, $sformatf("D vec %0d", i), int'(d_val), int'(t.d));
      check("R2", $sformatf("bit vec %0d", i), int'(msg_bit), int'(t.b));
      check("R4", $sformatf("no request after vec %0d", i), int'(elem_ready), 0);
    end

    // R5/R4: stalled source, three idle load cycles per element
    run_vec(TBL[2], 3, lat);
    check("R5", "latency with stalls", lat, 50 * 3 + 3 + 3 * 3);
    check("R5", "D with stalls", int'(d_val), 6);
    check("R5", "bit with stalls", int'(msg_bit), 1);

    // R6: result frozen while inputs move after completion
    run_vec(TBL[1], 0, lat);
    mod_q      = 16'd1000;
    ct_v       = 16'd3;
    vec_len    = 6'd5;
    elem_u     = 16'd77;
    elem_s     = 16'd88;
    elem_valid = 1'b1;
    repeat (8) @(negedge clk);
    check("R6", "done held", int'(done), 1);
    check("R6", "D held", int'(d_val), 17);
    check("R6", "bit held", int'(msg_bit), 0);
    check("R4", "no request while done", int'(elem_ready), 0);
    elem_valid = 1'b0;

    // R3: reset after a completed run clears outputs
    rst = 1'b1;
    @(negedge clk);
    check("R3", "done cleared", int'(done), 0);
    check("R3", "d_val cleared", int'(d_val), 0);
    check("R3", "msg_bit cleared", int'(msg_bit), 0);
    check("R3", "elem_ready cleared", int'(elem_ready), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule